// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Sensing

This block is one bank of general-purpose pins, each bit of which can be driven or read. An output latch holds the value to drive, and a direction bit picks whether the pin is driven. Software controls the bank through a small register window on a single-cycle bus. Writes take effect at the next clock edge. Read data is combinational from the address.

Every pin can also raise an interrupt. Each pin has its own enable bit and three sense-type bits. Together these select rising edge, falling edge, both edges, high level or low level. Pin inputs pass through a two-stage synchroniser. Edges are found by comparing the synchronised sample with the sample from the cycle before. A detected event sets a sticky status bit, and software clears that bit by writing 1 to it. All pending, enabled status bits are ORed onto a single interrupt line.

Top module: `gpio_sense_bank`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `pin_oe` and `pin_out` are zero and `irq` is low. The zero sense setting means falling edge.
- R2: A write to byte offset 0x00 loads the output latch, and the latch is driven on `pin_out`. A write to 0x04 loads the direction mask, which appears on `pin_oe`; a 1 makes that pin an output. A read of 0x00 returns the latch bit for output pins and the synchronised pin for input pins. The synchronised pin lags `pin_in` by two clock edges.
- R3: With sense bits t1=0 and t2=0, t0=1 detects a rising edge and t0=0 detects a falling edge. The status bit becomes visible on the third rising clock edge after the change at `pin_in`.
- R4: With t1=0 and t2=1, both rising and falling edges are detected.
- R5: With t1=1, detection is by level: t0=1 means active high and t0=0 means active low. The status bit is set again on every cycle that the level stays active, so a clear does not hold while the level stays active.
- R6: Status sits at offset 0x18. Writing 1 to a status bit clears it, and writing 0 leaves it alone. If a new event and a clear of the same bit fall in the same cycle, the bit stays set.
- R7: The interrupt enable sits at 0x08. A status bit is set only while its enable bit is 1.
- R8: `irq` is high exactly when some status bit and its enable bit are both 1. Clearing an enable bit drops that bit's share of `irq` but leaves its status bit unchanged.
- R9: Sense bits t0, t1 and t2 sit at 0x0C, 0x10 and 0x14, and all configuration registers read back as written. Any other offset reads zero, and writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Drive enable per pin (1 = output) |
| irq | output | 1 | Combined interrupt |

## Verification
Two functions of the status register can land on the same bit in the same clock edge. One is a detected event setting the bit. The other is a software write-1 clearing it. The bench provokes this in two ways. First, a level-sensitive pin is held active while its bit is cleared. Second, a pin is toggled exactly two cycles before a clear write, so that the edge is detected in the clear cycle. Both cases are judged against a behavioural model that is compared on every clock, and by a direct read of status afterwards. That read must show the bit still set. A partial clear checks that bits written with 0 survive the same write.

// File: rtl/gpio_bank_pkg.sv
// Package: register offsets and the sense decode shared by the bank.
// Assumes byte offsets on a 32-bit register window.
package gpio_bank_pkg;

    localparam int OFS_DATA = 'h00;
    localparam int OFS_DIR  = 'h04;
    localparam int OFS_IEN  = 'h08;
    localparam int OFS_T0   = 'h0C;
    localparam int OFS_T1   = 'h10;
    localparam int OFS_T2   = 'h14;
    localparam int OFS_STAT = 'h18;

    // Decide whether one pin meets its sense condition this cycle.
    function automatic logic sense_hit(input logic t0, input logic t1,
                                       input logic t2, input logic cur,
                                       input logic prev);
        logic r;
        if (t1)
            r = t0 ? cur : ~cur;          // level: high or low
        else if (t2)
            r = cur ^ prev;               // any edge
        else if (t0)
            r = cur & ~prev;              // rising edge
        else
            r = ~cur & prev;              // falling edge
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
// Two-flop synchroniser plus a history stage.
// Assumes pin_in is asynchronous. Outputs the synchronised level and the
// level one cycle earlier. All stages reset to zero.
module gpio_sync2 #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    logic [WIDTH-1:0] meta_q, sync_q, hist_q;

    // Shift pins through metastability, sync and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign cur  = sync_q;
    assign prev = hist_q;
endmodule

// File: rtl/gpio_sense_detect.sv
// Per-pin sense detector: applies each pin's type bits to its current and
// previous synchronised level. Purely combinational.
module gpio_sense_detect
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] prev,
    input  logic [WIDTH-1:0] t0,
    input  logic [WIDTH-1:0] t1,
    input  logic [WIDTH-1:0] t2,
    output logic [WIDTH-1:0] hit
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // Evaluate the sense condition for pin i.
        always_comb hit[i] = sense_hit(t0[i], t1[i], t2[i], cur[i], prev[i]);
    end
endmodule

// File: rtl/gpio_status_reg.sv
// Sticky interrupt status with write-1-to-clear and the combined line.
// Assumes clr is a one-cycle mask from the register decode. A set in the
// same cycle as a clear wins.
module gpio_status_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] hit,
    input  logic [WIDTH-1:0] enable,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] status,
    output logic             irq
);
    logic [WIDTH-1:0] status_q;
    logic [WIDTH-1:0] set_vec;

    // Only enabled pins may record an event.
    assign set_vec = hit & enable;

    // Update sticky bits: clear on request, then apply new events.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr) | set_vec;
    end

    assign status = status_q;
    assign irq    = |(status_q & enable);

    assert_set_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q)) & ~$past(enable)) == '0);

    assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & $past(hit & enable)) == $past(hit & enable));

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & $past(clr & ~(hit & enable))) == '0);

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (enable != '0));
endmodule

// File: rtl/gpio_regfile.sv
// Register file and bus decode: output latch, direction, enable and three
// sense-type registers. Produces the status clear mask and the read mux.
// Assumes a single-cycle bus; writes land at the clock edge, reads are
// combinational.
module gpio_regfile
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_sync,
    input  logic [WIDTH-1:0]  status,
    output logic [WIDTH-1:0]  out_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  en_q,
    output logic [WIDTH-1:0]  t0_q,
    output logic [WIDTH-1:0]  t1_q,
    output logic [WIDTH-1:0]  t2_q,
    output logic [WIDTH-1:0]  clr
);
    logic sel_data, sel_dir, sel_ien, sel_t0, sel_t1, sel_t2, sel_stat;

    // Decode the register selected by the address.
    always_comb begin
        sel_data = (bus_addr == ADDR_W'(OFS_DATA));
        sel_dir  = (bus_addr == ADDR_W'(OFS_DIR));
        sel_ien  = (bus_addr == ADDR_W'(OFS_IEN));
        sel_t0   = (bus_addr == ADDR_W'(OFS_T0));
        sel_t1   = (bus_addr == ADDR_W'(OFS_T1));
        sel_t2   = (bus_addr == ADDR_W'(OFS_T2));
        sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
    end

    // Load configuration registers on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
            en_q  <= '0;
            t0_q  <= '0;
            t1_q  <= '0;
            t2_q  <= '0;
        end else if (bus_wr) begin
            if (sel_data) out_q <= bus_wdata;
            if (sel_dir)  dir_q <= bus_wdata;
            if (sel_ien)  en_q  <= bus_wdata;
            if (sel_t0)   t0_q  <= bus_wdata;
            if (sel_t1)   t1_q  <= bus_wdata;
            if (sel_t2)   t2_q  <= bus_wdata;
        end
    end

    // Form the write-1-to-clear mask for the status register.
    assign clr = (bus_wr && sel_stat) ? bus_wdata : '0;

    // Select read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (sel_data) bus_rdata = (out_q & dir_q) | (pin_sync & ~dir_q);
        if (sel_dir)  bus_rdata = dir_q;
        if (sel_ien)  bus_rdata = en_q;
        if (sel_t0)   bus_rdata = t0_q;
        if (sel_t1)   bus_rdata = t1_q;
        if (sel_t2)   bus_rdata = t2_q;
        if (sel_stat) bus_rdata = status;
    end

    assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_wr && sel_dir)) |-> (dir_q == $past(bus_wdata)));

    assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_wr && sel_data)) |-> $stable(out_q));
endmodule

// File: rtl/gpio_sense_bank.sv
// Top: one GPIO bank with per-pin interrupt sensing. Connects the
// synchroniser, sense detector, status register and register file.
// Assumes one clock domain and a synchronous active-low reset.
module gpio_sense_bank #(
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              irq
);
    logic [WIDTH-1:0] cur, prev, hit, status, clr;
    logic [WIDTH-1:0] en_q, t0_q, t1_q, t2_q;

    gpio_sync2 #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cur(cur), .prev(prev)
    );

    gpio_sense_detect #(.WIDTH(WIDTH)) u_detect (
        .cur(cur), .prev(prev), .t0(t0_q), .t1(t1_q), .t2(t2_q), .hit(hit)
    );

    gpio_status_reg #(.WIDTH(WIDTH)) u_status (
        .clk(clk), .rst_n(rst_n), .hit(hit), .enable(en_q), .clr(clr),
        .status(status), .irq(irq)
    );

    gpio_regfile #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_sync(cur),
        .status(status), .out_q(pin_out), .dir_q(pin_oe), .en_q(en_q),
        .t0_q(t0_q), .t1_q(t1_q), .t2_q(t2_q), .clr(clr)
    );
endmodule

// File: tb/test_gpio_sense_bank.sv
// Bench: behavioural reference model compared on every clock, plus
// directed reads with hand-computed expectations.
module test_gpio_sense_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    gpio_sense_bank i_gpio_sense_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_out = '0, m_dir = '0, m_en = '0;
    logic [31:0] m_t0 = '0, m_t1 = '0, m_t2 = '0, m_st = '0;
    logic [31:0] hq[$] = '{32'h0, 32'h0, 32'h0};

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return (m_out & m_dir) | (hq[1] & ~m_dir);
            8'h04: return m_dir;
            8'h08: return m_en;
            8'h0C: return m_t0;
            8'h10: return m_t1;
            8'h14: return m_t2;
            8'h18: return m_st;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00, 8'h04: return "R2";
            8'h08: return "R7";
            8'h18: return "R6";
            default: return "R9";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = '0; m_dir = '0; m_en = '0;
            m_t0 = '0; m_t1 = '0; m_t2 = '0; m_st = '0;
            hq = '{32'h0, 32'h0, 32'h0};
        end else begin
            logic [31:0] ev;
            logic [31:0] clrm;
            ev = '0;
            for (int i = 0; i < 32; i++) begin
                logic c, p;
                c = hq[1][i];
                p = hq[2][i];
                if (m_t1[i])      ev[i] = m_t0[i] ? c : !c;
                else if (m_t2[i]) ev[i] = c != p;
                else if (m_t0[i]) ev[i] = c && !p;
                else              ev[i] = !c && p;
            end
            clrm = (bus_wr && bus_addr == 8'h18) ? bus_wdata : '0;
            m_st = (m_st & ~clrm) | (ev & m_en);
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: m_out = bus_wdata;
                    8'h04: m_dir = bus_wdata;
                    8'h08: m_en  = bus_wdata;
                    8'h0C: m_t0  = bus_wdata;
                    8'h10: m_t1  = bus_wdata;
                    8'h14: m_t2  = bus_wdata;
                    default: ;
                endcase
            end
            hq.push_front(pin_in);
            hq = hq[0:2];
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] er;
            logic        ei;
            er = m_read(bus_addr);
            ei = |(m_st & m_en);
            n_cmp++;
            if (pin_out !== m_out || pin_oe !== m_dir) begin
                n_bad++;
                $display("FAIL R2 out/oe actual %h/%h expected %h/%h", pin_out, pin_oe, m_out, m_dir);
            end else if (irq !== ei) begin
                n_bad++;
                $display("FAIL R8 irq actual %b expected %b", irq, ei);
            end else if (bus_rdata !== er) begin
                n_bad++;
                $display("FAIL %s rdata @%h actual %h expected %h", tag_of(bus_addr), bus_addr, bus_rdata, er);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input logic [7:0] a, input logic w, input logic [31:0] d);
        @(negedge clk);
        #2;
        bus_addr = a; bus_wr = w; bus_wdata = d;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(a, 1'b1, d);
        cyc(8'h00, 1'b0, 32'h0);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(8'h00, 1'b0, 32'h0);
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        cyc(a, 1'b0, 32'h0);
        #1;
        n_cmp++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s read @%h actual %h expected %h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic expect_bit(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk); #2 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a <= 'h18; a += 4) expect_rd(8'(a), 32'h0, "R1");
        expect_bit(irq, 1'b0, "R1 irq");
        expect_bit(|pin_oe, 1'b0, "R1 oe");

        // R9: unmapped offset reads zero, write ignored
        wr(8'h1C, 32'hFFFF_FFFF);
        expect_rd(8'h1C, 32'h0, "R9");
        expect_rd(8'h00, 32'h0, "R9 data untouched");

        // R2: latch, direction and mixed readback
        wr(8'h04, 32'h0000_FFFF);
        wr(8'h00, 32'h1234_5678);
        pin_in = 32'hCAFE_BEEF;
        idle(3);
        expect_rd(8'h00, 32'hCAFE_5678, "R2");
        expect_bit(pin_oe == 32'h0000_FFFF && pin_out == 32'h1234_5678, 1'b1, "R2 pins");
        pin_in = '0;
        idle(4);

        // R7: event with enable off leaves status clear
        wr(8'h0C, 32'h1);
        pin_in[0] = 1'b1;
        idle(4);
        expect_rd(8'h18, 32'h0, "R7");
        pin_in[0] = 1'b0;
        idle(4);

        // Configure: b0 rise, b1 fall, b2 both, b3 high level, b4 low level
        wr(8'h0C, 32'h0D);
        wr(8'h10, 32'h18);
        wr(8'h14, 32'h04);
        wr(8'h08, 32'h1F);
        expect_rd(8'h10, 32'h18, "R9 readback");
        idle(2);
        // R5: low level active with pins at zero; clear does not hold
        expect_rd(8'h18, 32'h10, "R5 low level");
        wr(8'h18, 32'h10);
        expect_rd(8'h18, 32'h10, "R5 re-set");
        pin_in[4] = 1'b1;
        idle(4);
        wr(8'h18, 32'h10);
        expect_rd(8'h18, 32'h0, "R5 released");

        // R3: rising detected, falling ignored on b0
        pin_in[0] = 1'b1;
        idle(1);
        expect_rd(8'h18, 32'h0, "R3 latency");
        expect_rd(8'h18, 32'h01, "R3 rise");
        expect_bit(irq, 1'b1, "R8 irq");
        wr(8'h18, 32'h01);
        pin_in[0] = 1'b0;
        idle(4);
        expect_rd(8'h18, 32'h0, "R3 fall ignored");

        // R3: falling mode on b1
        pin_in[1] = 1'b1;
        idle(4);
        expect_rd(8'h18, 32'h0, "R3 rise ignored");
        pin_in[1] = 1'b0;
        idle(4);
        expect_rd(8'h18, 32'h02, "R3 fall");
        wr(8'h18, 32'h02);

        // R4: both edges on b2
        pin_in[2] = 1'b1;
        idle(4);
        expect_rd(8'h18, 32'h04, "R4 rise");
        wr(8'h18, 32'h04);
        pin_in[2] = 1'b0;
        idle(4);
        expect_rd(8'h18, 32'h04, "R4 fall");
        wr(8'h18, 32'h04);

        // R5: high level on b3
        pin_in[3] = 1'b1;
        idle(4);
        expect_rd(8'h18, 32'h08, "R5 high level");
        pin_in[3] = 1'b0;
        idle(3);
        wr(8'h18, 32'h08);
        expect_rd(8'h18, 32'h0, "R5 high released");

        // R8: masking drops irq but keeps status
        pin_in[0] = 1'b1;
        idle(4);
        wr(8'h08, 32'h1E);
        expect_bit(irq, 1'b0, "R8 masked");
        expect_rd(8'h18, 32'h01, "R8 status kept");
        wr(8'h08, 32'h1F);
        expect_bit(irq, 1'b1, "R8 unmasked");
        wr(8'h18, 32'h01);
        pin_in[0] = 1'b0;
        idle(4);

        // R6: edge arriving in the same cycle as a clear keeps the bit
        wr(8'h0C, 32'h2D);
        wr(8'h08, 32'h3F);
        cyc(8'h00, 1'b0, 32'h0);
        pin_in[5] = 1'b1;
        cyc(8'h00, 1'b0, 32'h0);
        cyc(8'h18, 1'b1, 32'hFFFF_FFFF);
        cyc(8'h00, 1'b0, 32'h0);
        expect_rd(8'h18, 32'h20, "R6 set wins");

        // R6: partial clear leaves other bits
        pin_in[0] = 1'b1;
        idle(4);
        expect_rd(8'h18, 32'h21, "R6 two pending");
        wr(8'h18, 32'h01);
        expect_rd(8'h18, 32'h20, "R6 partial clear");
        wr(8'h18, 32'h20);
        expect_rd(8'h18, 32'h0, "R6 cleared");
        idle(3);

        finish_run();
    end
endmodule